// File: doc/BRIEF.md
# Vector Branch Condition Evaluator

This block resolves a conditional branch that spans a vector of condition fields. A start pulse latches the branch options, the mode bits, the vector length, the predicate mask and the count register. The block then walks the elements from index 0 upward, one element per clock. For each element it picks one bit of a 4-bit condition field, applies the predicate, tests the bit against the branch options, updates the count register under the selected decrement policy and may cut the vector length short. The per-element results merge either as "any element succeeds" or as "every element succeeds".

When the walk ends, the block raises a one-cycle done pulse. At the same time it presents the branch decision, the updated count value and the possibly reduced vector length. These outputs are registered and stay unchanged until the next done pulse. The bank of condition fields is read live, so the surrounding pipeline keeps it stable while an evaluation is running. Target address generation and link register handling belong to neighbouring logic.

Top module: `vec_branch_eval`

## Requirements
- R1: Element e reads condition field F and, inside it, nibble bit `bi_i[1:0]`. Field F lives at bits `fields_i[4F+3:4F]`. With `bi_vec_i`=1, F = (16·`bi_i[4:2]` + e) mod 128. With `bi_vec_i`=0, F = 16·`bi_i[4:2]` for every element.
- R2: The condition part passes when `bo_i[0]`=1 or when the tested bit equals `bo_i[1]`. The count part is evaluated on the count value after this element's decrement. It passes when `bo_i[2]`=1, or when (count nonzero) XOR `bo_i[3]` is 1. When `wide_i`=0, only the low 32 bits of the count are checked for zero. An element succeeds when both parts pass.
- R3: With `all_i`=0, the walk stops at the first tested element that succeeds, and the branch is taken. If no tested element succeeds, the branch is not taken.
- R4: With `all_i`=1, the walk stops at the first tested element that fails. The branch is taken only if at least one element was tested and every tested element succeeded.
- R5: An element with predicate bit 0 is skipped when `zero_i`=0: it has no test and no count update apart from R7. When `zero_i`=1, the element is tested with `snz_i` in place of the field bit.
- R6: For a tested element the count decrements by one only when `bo_i[2]`=0, and then according to the mode. With `ctr_test_i`=0 and `cti_i`=0 it always decrements. With `ctr_test_i`=0 and `cti_i`=1 it never decrements. With `ctr_test_i`=1 and `cti_i`=0 it decrements when the condition part passes. With `ctr_test_i`=1 and `cti_i`=1 it decrements when the condition part fails.
- R7: A skipped element decrements the count by one only when `bo_i[2]`=0, `ctr_test_i`=0 and `cti_i`=1.
- R8: With `vlset_i`=1, a tested element whose success equals `vsb_i` sets the reported length to its own index and ends the walk. The count update of that element is applied first.
- R9: With `bi_vec_i`=0, only the first non-skipped element is tested, and the walk ends there.
- R10: With a length of 0, done rises in the cycle after start, the branch is not taken, the count is returned unchanged and the length is 0. If every element is skipped, the branch is not taken and the length is unchanged.
- R11: Elements advance by one per clock. If start is sampled with length 0, done is seen 1 cycle later. Otherwise done is seen k+2 cycles after start, where k is the index of the last element visited. A start pulse that arrives while a walk is running is ignored.
- R12: Done is a single-cycle pulse. The decision, count and length outputs change only together with done and are held otherwise.
- R13: After reset, done, taken, count and length outputs are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Begin an evaluation (ignored while busy) |
| bo_i | input | 4 | Branch options: [0] ignore condition, [1] wanted bit value, [2] ignore count, [3] count-zero sense |
| bi_i | input | 5 | [4:2] field group, [1:0] bit within field |
| bi_vec_i | input | 1 | 1: one field per element, 0: single scalar field |
| all_i | input | 1 | 1: AND-merge of element results, 0: OR-merge |
| cti_i | input | 1 | Count decrement inversion |
| vsb_i | input | 1 | Truncate length on success (1) or on failure (0) |
| ctr_test_i | input | 1 | Count decrement depends on the condition test |
| vlset_i | input | 1 | Enable length truncation |
| snz_i | input | 1 | Substitute bit for masked elements when zeroing |
| zero_i | input | 1 | 1: masked elements are tested with the substitute bit, 0: skipped |
| wide_i | input | 1 | 1: full-width count zero check, 0: low 32 bits |
| vl_i | input | VL_W | Vector length (clamped to MAX_VL) |
| pred_i | input | MAX_VL | Predicate mask, bit e for element e |
| fields_i | input | 4·NFIELDS | Condition field bank, held stable while busy |
| ctr_i | input | CTR_W | Count register value |
| done_o | output | 1 | One-cycle completion pulse |
| taken_o | output | 1 | Branch decision |
| ctr_o | output | CTR_W | Updated count value |
| vl_o | output | VL_W | Updated vector length |

## Verification
A wrong element index or a wrong field offset changes which bit is tested. This shows up on `taken_o` and, through the test-driven decrement policies, on `ctr_o` at the very next done pulse. A corrupted merge or stop decision moves the done pulse to a different cycle, so done latency is compared against the element index at which the walk should end. A bad decrement or truncation decision shows up as a count that is off by the number of affected elements, or as a length that differs from the expected element index. Outputs are also rechecked two cycles after done, which catches values that drift while the outputs should be held.

// File: rtl/vbe_pkg.sv
package vbe_pkg;

   typedef struct packed {
      logic       all_m;
      logic       cti;
      logic       vsb;
      logic       ctr_test;
      logic       vlset;
      logic       snz;
      logic       zero;
      logic       wide;
      logic       bvec;
      logic [3:0] bo;
      logic [4:0] bi;
   } vbe_cfg_t;

endpackage

// File: rtl/vbe_bit_pick.sv
module vbe_bit_pick #(
   parameter int NFIELDS = 128,
   parameter int FLD_W   = 4,
   parameter int BI_W    = 5,
   parameter int IDX_W   = 6
) (
   input  logic [NFIELDS*FLD_W-1:0] fields_i,
   input  logic [BI_W-1:0]          bi_i,
   input  logic                     bvec_i,
   input  logic [IDX_W-1:0]         elem_i,
   output logic                     bit_o
);
   localparam int FI_W  = $clog2(NFIELDS);
   localparam int SEL_W = $clog2(FLD_W);
   localparam int HI_W  = BI_W - SEL_W;
   localparam int SHIFT = FI_W - HI_W;

   generate
      if ((1 << FI_W) != NFIELDS) begin : g_bad_nf
         $error("NFIELDS must be a power of two");
      end
      if ((1 << SEL_W) != FLD_W) begin : g_bad_fw
         $error("FLD_W must be a power of two");
      end
      if (SHIFT < 1) begin : g_bad_shift
         $error("field group must leave room for an element offset");
      end
   endgenerate

   logic [FI_W-1:0]    base;
   logic [FI_W-1:0]    elem_fi;
   logic [FI_W-1:0]    fidx;
   logic [SEL_W-1:0]   bsel;
   logic [NFIELDS-1:0] col;

   assign bsel = bi_i[SEL_W-1:0];
   assign base = {bi_i[BI_W-1:SEL_W], {SHIFT{1'b0}}};

   generate
      if (IDX_W >= FI_W) begin : g_idx_trunc
         assign elem_fi = elem_i[FI_W-1:0];
      end else begin : g_idx_ext
         assign elem_fi = {{(FI_W-IDX_W){1'b0}}, elem_i};
      end
   endgenerate

   assign fidx = base + (bvec_i ? elem_fi : {FI_W{1'b0}});

   generate
      for (genvar f = 0; f < NFIELDS; f++) begin : g_col
         logic [FLD_W-1:0] nib;
         assign nib    = fields_i[f*FLD_W +: FLD_W];
         assign col[f] = nib[bsel];
      end
   endgenerate

   assign bit_o = col[fidx];

endmodule

// File: rtl/vbe_elem_eval.sv
module vbe_elem_eval (
   input  logic pred_bit_i,
   input  logic field_bit_i,
   input  logic zero_i,
   input  logic snz_i,
   input  logic bo_uncond_i,
   input  logic bo_want_i,
   input  logic bo_noctr_i,
   input  logic ctr_test_i,
   input  logic cti_i,
   output logic skip_o,
   output logic cond_o,
   output logic dec_o
);
   logic tbit;
   logic test_dec;
   logic skip_dec;

   always_comb begin
      skip_o   = !pred_bit_i && !zero_i;
      tbit     = pred_bit_i ? field_bit_i : snz_i;
      cond_o   = bo_uncond_i || (tbit == bo_want_i);
      if (ctr_test_i)
         test_dec = cond_o ^ cti_i;
      else
         test_dec = !cti_i;
      skip_dec = !ctr_test_i && cti_i;
      dec_o    = !bo_noctr_i && (skip_o ? skip_dec : test_dec);
   end

endmodule

// File: rtl/vbe_ctr_step.sv
module vbe_ctr_step #(
   parameter int CTR_W    = 64,
   parameter int NARROW_W = 32
) (
   input  logic [CTR_W-1:0] ctr_i,
   input  logic             dec_i,
   input  logic             wide_i,
   input  logic             nochk_i,
   input  logic             sense_i,
   output logic [CTR_W-1:0] ctr_o,
   output logic             ok_o
);
   localparam logic [CTR_W-1:0] CTR_ONE = 1;

   generate
      if (NARROW_W < 1 || NARROW_W >= CTR_W) begin : g_bad_w
         $error("NARROW_W must be between 1 and CTR_W-1");
      end
   endgenerate

   logic nz;

   always_comb begin
      ctr_o = dec_i ? (ctr_i - CTR_ONE) : ctr_i;
      nz    = wide_i ? (|ctr_o) : (|ctr_o[NARROW_W-1:0]);
      ok_o  = nochk_i || (nz ^ sense_i);
   end

endmodule

// File: rtl/vec_branch_eval.sv
module vec_branch_eval
   import vbe_pkg::*;
#(
   parameter int MAX_VL   = 64,
   parameter int NFIELDS  = 128,
   parameter int FLD_W    = 4,
   parameter int CTR_W    = 64,
   parameter int NARROW_W = 32,
   localparam int VL_W    = $clog2(MAX_VL + 1)
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     start_i,
   input  logic [3:0]               bo_i,
   input  logic [4:0]               bi_i,
   input  logic                     bi_vec_i,
   input  logic                     all_i,
   input  logic                     cti_i,
   input  logic                     vsb_i,
   input  logic                     ctr_test_i,
   input  logic                     vlset_i,
   input  logic                     snz_i,
   input  logic                     zero_i,
   input  logic                     wide_i,
   input  logic [VL_W-1:0]          vl_i,
   input  logic [MAX_VL-1:0]        pred_i,
   input  logic [NFIELDS*FLD_W-1:0] fields_i,
   input  logic [CTR_W-1:0]         ctr_i,
   output logic                     done_o,
   output logic                     taken_o,
   output logic [CTR_W-1:0]         ctr_o,
   output logic [VL_W-1:0]          vl_o
);
   localparam int               IDX_W   = $clog2(MAX_VL);
   localparam logic [VL_W-1:0]  VL_CAP  = VL_W'(MAX_VL);
   localparam logic [VL_W-1:0]  ONE_VL  = 1;
   localparam logic [CTR_W-1:0] CTR_ONE = 1;

   generate
      if (MAX_VL < 2) begin : g_bad_vl
         $error("MAX_VL must be at least 2");
      end
      if (FLD_W != 4) begin : g_bad_fld
         $error("condition fields are four bits wide");
      end
   endgenerate

   vbe_cfg_t          cfg_q;
   logic              busy_q;
   logic [VL_W-1:0]   idx_q;
   logic [VL_W-1:0]   vl_q;
   logic [MAX_VL-1:0] pred_q;
   logic [CTR_W-1:0]  ctr_q;
   logic              tested_q;
   logic              okacc_q;
   logic              done_q;
   logic              taken_q;
   logic [CTR_W-1:0]  ctr_res_q;
   logic [VL_W-1:0]   vl_res_q;

   logic [VL_W-1:0]   vl_eff;
   logic [IDX_W-1:0]  elem;
   logic              fbit;
   logic              skip;
   logic              cond;
   logic              dec;
   logic [CTR_W-1:0]  ctr_nx;
   logic              cok;
   logic              eok;
   logic              trunc;
   logic              last;
   logic              stop;
   logic              tested_n;
   logic              okacc_n;
   logic              take_res;
   logic [VL_W-1:0]   vl_res;

   assign vl_eff = (vl_i > VL_CAP) ? VL_CAP : vl_i;
   assign elem   = idx_q[IDX_W-1:0];

   vbe_bit_pick #(
      .NFIELDS (NFIELDS),
      .FLD_W   (FLD_W),
      .BI_W    (5),
      .IDX_W   (IDX_W)
   ) u_pick (
      .fields_i (fields_i),
      .bi_i     (cfg_q.bi),
      .bvec_i   (cfg_q.bvec),
      .elem_i   (elem),
      .bit_o    (fbit)
   );

   vbe_elem_eval u_elem (
      .pred_bit_i  (pred_q[elem]),
      .field_bit_i (fbit),
      .zero_i      (cfg_q.zero),
      .snz_i       (cfg_q.snz),
      .bo_uncond_i (cfg_q.bo[0]),
      .bo_want_i   (cfg_q.bo[1]),
      .bo_noctr_i  (cfg_q.bo[2]),
      .ctr_test_i  (cfg_q.ctr_test),
      .cti_i       (cfg_q.cti),
      .skip_o      (skip),
      .cond_o      (cond),
      .dec_o       (dec)
   );

   vbe_ctr_step #(
      .CTR_W    (CTR_W),
      .NARROW_W (NARROW_W)
   ) u_ctr (
      .ctr_i   (ctr_q),
      .dec_i   (dec),
      .wide_i  (cfg_q.wide),
      .nochk_i (cfg_q.bo[2]),
      .sense_i (cfg_q.bo[3]),
      .ctr_o   (ctr_nx),
      .ok_o    (cok)
   );

   // per-element step order: test, count update, truncation, stop, decision
   always_comb begin
      eok      = cond && cok;
      trunc    = !skip && cfg_q.vlset && (cfg_q.vsb ? eok : !eok);
      last     = (idx_q + ONE_VL) >= vl_q;
      stop     = last || (!skip && (!cfg_q.bvec || trunc ||
                                    (cfg_q.all_m ? !eok : eok)));
      tested_n = tested_q || !skip;
      okacc_n  = okacc_q && (skip || eok);
      take_res = cfg_q.all_m ? (tested_n && okacc_n) : (!skip && eok);
      vl_res   = trunc ? idx_q : vl_q;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cfg_q     <= '0;
         busy_q    <= 1'b0;
         idx_q     <= '0;
         vl_q      <= '0;
         pred_q    <= '0;
         ctr_q     <= '0;
         tested_q  <= 1'b0;
         okacc_q   <= 1'b1;
         done_q    <= 1'b0;
         taken_q   <= 1'b0;
         ctr_res_q <= '0;
         vl_res_q  <= '0;
      end else begin
         done_q <= 1'b0;
         if (!busy_q && start_i) begin
            cfg_q.all_m    <= all_i;
            cfg_q.cti      <= cti_i;
            cfg_q.vsb      <= vsb_i;
            cfg_q.ctr_test <= ctr_test_i;
            cfg_q.vlset    <= vlset_i;
            cfg_q.snz      <= snz_i;
            cfg_q.zero     <= zero_i;
            cfg_q.wide     <= wide_i;
            cfg_q.bvec     <= bi_vec_i;
            cfg_q.bo       <= bo_i;
            cfg_q.bi       <= bi_i;
            vl_q           <= vl_eff;
            pred_q         <= pred_i;
            ctr_q          <= ctr_i;
            idx_q          <= '0;
            tested_q       <= 1'b0;
            okacc_q        <= 1'b1;
            if (vl_eff == '0) begin
               done_q    <= 1'b1;
               taken_q   <= 1'b0;
               ctr_res_q <= ctr_i;
               vl_res_q  <= '0;
            end else begin
               busy_q <= 1'b1;
            end
         end else if (busy_q) begin
            ctr_q    <= ctr_nx;
            tested_q <= tested_n;
            okacc_q  <= okacc_n;
            if (stop) begin
               busy_q    <= 1'b0;
               done_q    <= 1'b1;
               taken_q   <= take_res;
               ctr_res_q <= ctr_nx;
               vl_res_q  <= vl_res;
            end else begin
               idx_q <= idx_q + ONE_VL;
            end
         end
      end
   end

   assign done_o  = done_q;
   assign taken_o = taken_q;
   assign ctr_o   = ctr_res_q;
   assign vl_o    = vl_res_q;

   AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      done_q && !start_i |=> !done_q); // R12

   AST_HOLD_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
      !done_q |-> $stable(taken_q) && $stable(ctr_res_q) && $stable(vl_res_q)); // R12

   AST_ELEM_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
      busy_q && !stop |=> busy_q && (idx_q == $past(idx_q) + ONE_VL)); // R11

   AST_CTR_STEP_MAX1: assert property (@(posedge clk) disable iff (!rst_n)
      busy_q |=> (ctr_q == $past(ctr_q)) || (ctr_q == $past(ctr_q) - CTR_ONE)); // R6

   AST_EMPTY_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
      start_i && !busy_q && (vl_i == '0) |=> done_q && !taken_q && (vl_res_q == '0)
                                            && (ctr_res_q == $past(ctr_i))); // R10

   AST_VL_NO_GROW: assert property (@(posedge clk) disable iff (!rst_n)
      done_q |-> vl_res_q <= vl_q); // R8

endmodule

// File: tb/sim_vec_branch_eval.sv
module sim_vec_branch_eval;
   localparam int MAX_VL = 8;
   localparam int NF     = 128;
   localparam int CW     = 64;
   localparam int VLW    = $clog2(MAX_VL + 1);

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              start_i = 1'b0;
   logic [3:0]        bo_i = '0;
   logic [4:0]        bi_i = '0;
   logic              bi_vec_i = 1'b0, all_i = 1'b0, cti_i = 1'b0, vsb_i = 1'b0;
   logic              ctr_test_i = 1'b0, vlset_i = 1'b0, snz_i = 1'b0, zero_i = 1'b0, wide_i = 1'b0;
   logic [VLW-1:0]    vl_i = '0;
   logic [MAX_VL-1:0] pred_i = '0;
   logic [NF*4-1:0]   fields_i = '0;
   logic [CW-1:0]     ctr_i = '0;
   logic              done_o, taken_o;
   logic [CW-1:0]     ctr_o;
   logic [VLW-1:0]    vl_o;

   int nchk = 0;
   int nfail = 0;
   int cyc = 0;

   vec_branch_eval #(.MAX_VL(MAX_VL), .NFIELDS(NF), .FLD_W(4), .CTR_W(CW), .NARROW_W(32)) u0 (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .bo_i(bo_i), .bi_i(bi_i),
      .bi_vec_i(bi_vec_i), .all_i(all_i), .cti_i(cti_i), .vsb_i(vsb_i),
      .ctr_test_i(ctr_test_i), .vlset_i(vlset_i), .snz_i(snz_i), .zero_i(zero_i),
      .wide_i(wide_i), .vl_i(vl_i), .pred_i(pred_i), .fields_i(fields_i),
      .ctr_i(ctr_i), .done_o(done_o), .taken_o(taken_o), .ctr_o(ctr_o), .vl_o(vl_o));

   always #2 clk = ~clk;

   task automatic chk(input bit ok, input string tag, input string what,
                      input logic [63:0] act, input logic [63:0] exp);
      nchk++;
      if (!ok) begin
         nfail++;
         $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
      end
   endtask

   always @(posedge clk) begin
      cyc++;
      if (cyc > 190000) begin
         nfail++;
         $display("FAIL R11 watchdog actual=%0d expected<190000", cyc);
         $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
         $finish;
      end
   end

   // arithmetic reference built from the requirement text
   task automatic model(output bit tk, output logic [63:0] c, output int v, output int lat);
      bit tested = 0, okacc = 1, anyok = 0;
      int last = 0;
      int vl = int'(vl_i);
      c = ctr_i;
      v = vl;
      for (int e = 0; e < vl; e++) begin
         bit skip, tb, cond, dec, nz, eok, trunc;
         int fi;
         last = e;
         skip = !pred_i[e] && !zero_i;
         if (skip) begin
            if (!bo_i[2] && !ctr_test_i && cti_i) c = c - 1;
            continue;
         end
         fi = bi_vec_i ? ((int'(bi_i[4:2]) * 16 + e) % NF) : int'(bi_i[4:2]) * 16;
         tb = pred_i[e] ? fields_i[fi*4 + int'(bi_i[1:0])] : snz_i;
         cond = bo_i[0] || (tb == bo_i[1]);
         dec = !bo_i[2] && (ctr_test_i ? (cond ^ cti_i) : !cti_i);
         if (dec) c = c - 1;
         nz = wide_i ? (c != 0) : (c[31:0] != 0);
         eok = cond && (bo_i[2] || (nz ^ bo_i[3]));
         tested = 1;
         okacc = okacc && eok;
         if (eok) anyok = 1;
         trunc = vlset_i && (vsb_i ? eok : !eok);
         if (trunc) v = e;
         if (!bi_vec_i || trunc || (all_i ? !eok : eok)) break;
      end
      tk = all_i ? (tested && okacc) : anyok;
      lat = (vl == 0) ? 1 : last + 2;
   endtask

   task automatic apply(input string tag, input bit poke);
      bit etk;
      logic [63:0] ec;
      int ev, elat, lat;
      logic [63:0] keep_ctr;
      model(etk, ec, ev, elat);
      keep_ctr = ctr_i;
      start_i = 1'b1;
      @(negedge clk);
      start_i = 1'b0;
      lat = 1;
      while (!done_o && lat < 64) begin
         if (poke && lat == 2) begin
            start_i = 1'b1;
            ctr_i = ~keep_ctr;
         end
         @(negedge clk);
         start_i = 1'b0;
         ctr_i = keep_ctr;
         lat++;
      end
      chk(lat == elat, tag, "done latency", 64'(lat), 64'(elat));
      chk(taken_o == etk, tag, "taken", 64'(taken_o), 64'(etk));
      chk(ctr_o == ec, tag, "count", ctr_o, ec);
      chk(int'(vl_o) == ev, tag, "length", 64'(vl_o), 64'(ev));
      begin
         logic tk0 = taken_o;
         logic [63:0] c0 = ctr_o;
         logic [VLW-1:0] v0 = vl_o;
         @(negedge clk);
         chk(!done_o, "R12", "done pulse width", 64'(done_o), 64'd0);
         @(negedge clk);
         chk(taken_o == tk0 && ctr_o == c0 && vl_o == v0, "R12", "held outputs",
             {ctr_o[61:0], taken_o, 1'b0}, {c0[61:0], tk0, 1'b0});
      end
   endtask

   task automatic set_opts(input logic [3:0] bo, input logic [4:0] bi, input bit vec,
                           input bit al, input bit ci, input bit vs, input bit ct,
                           input bit vls, input bit sn, input bit sz, input bit wd,
                           input int vl, input logic [7:0] pr, input logic [63:0] c);
      bo_i = bo; bi_i = bi; bi_vec_i = vec; all_i = al; cti_i = ci; vsb_i = vs;
      ctr_test_i = ct; vlset_i = vls; snz_i = sn; zero_i = sz; wide_i = wd;
      vl_i = VLW'(vl); pred_i = pr; ctr_i = c;
   endtask

   task automatic rand_fields();
      for (int i = 0; i < NF * 4 / 32; i++) fields_i[i*32 +: 32] = $urandom;
   endtask

   function automatic logic [63:0] pick_ctr(input int k);
      case (k % 6)
         0: return 64'd0;
         1: return 64'd1;
         2: return 64'd2;
         3: return 64'h1_0000_0000;
         4: return 64'h1_0000_0001;
         default: return {32'h0, $urandom};
      endcase
   endfunction

   initial begin
      void'($urandom(32'd1234));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R13 reset state
      chk(!done_o && !taken_o && ctr_o == 0 && vl_o == 0, "R13", "reset outputs",
          {ctr_o[61:0], taken_o, done_o}, 64'd0);

      // R1 field offset and bit select, vector: field 50 bit 2 is the only one set
      fields_i = '0;
      fields_i[50*4 + 2] = 1'b1;
      set_opts(4'b0110, {3'd3, 2'd2}, 1, 0, 0, 0, 0, 0, 0, 0, 1, 4, 8'hff, 64'd7);
      apply("R1", 0);
      // R1/R9 scalar reads field 48 only, where bit 2 is clear
      set_opts(4'b0110, {3'd3, 2'd2}, 0, 0, 0, 0, 0, 0, 0, 0, 1, 4, 8'hff, 64'd7);
      apply("R1", 0);
      // R9 scalar picks first predicated element (index 2)
      fields_i = '0;
      set_opts(4'b0100, 5'd0, 0, 0, 0, 0, 0, 0, 0, 0, 1, 6, 8'b0000_0100, 64'd3);
      apply("R9", 0);
      // R10 empty vector
      set_opts(4'b0001, 5'd0, 1, 0, 0, 0, 0, 0, 0, 0, 1, 0, 8'hff, 64'd9);
      apply("R10", 0);
      // R10 / R7 every element skipped, skip-decrement policy active
      set_opts(4'b0000, 5'd0, 1, 1, 1, 0, 0, 0, 0, 0, 1, 5, 8'h00, 64'd20);
      apply("R7", 0);
      // R2 narrow count check: 2^32+1 decrements to 2^32, low half zero
      set_opts(4'b0001, 5'd0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 1, 8'h01, 64'h1_0000_0001);
      apply("R2", 0);
      set_opts(4'b0001, 5'd0, 0, 0, 0, 0, 0, 0, 0, 0, 1, 1, 8'h01, 64'h1_0000_0001);
      apply("R2", 0);
      // R11 start while busy ignored: all eight elements fail
      fields_i = '1;
      set_opts(4'b0100, 5'd0, 1, 0, 0, 0, 0, 0, 0, 0, 1, 8, 8'hff, 64'd5);
      apply("R11", 1);
      // R8 / R4 truncation on first failure at element 3
      fields_i = '0;
      for (int f = 0; f < 3; f++) fields_i[f*4] = 1'b1;
      set_opts(4'b0110, 5'd0, 1, 1, 0, 0, 0, 1, 0, 0, 1, 6, 8'hff, 64'd4);
      apply("R8", 0);
      // R5 zeroing: masked elements take the substitute bit
      set_opts(4'b0110, 5'd0, 1, 1, 0, 0, 0, 0, 1, 1, 1, 5, 8'b0000_0111, 64'd4);
      apply("R5", 0);

      // near-exhaustive sweep over ten option bits, random data
      for (int m = 0; m < 1024; m++) begin
         rand_fields();
         set_opts(4'($urandom), 5'($urandom), m[0], m[1], m[2], m[3], m[4], m[5],
                  m[6], m[7], m[8], int'($urandom % (MAX_VL + 1)),
                  m[9] ? 8'($urandom) : 8'hff, pick_ctr(int'($urandom)));
         apply("R3/R4/R5/R6/R7/R8/R9", 0);
      end
      // random sweep over everything
      for (int n = 0; n < 1200; n++) begin
         rand_fields();
         set_opts(4'($urandom), 5'($urandom), 1'($urandom), 1'($urandom), 1'($urandom),
                  1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom),
                  1'($urandom), int'($urandom % (MAX_VL + 1)), 8'($urandom),
                  pick_ctr(int'($urandom)));
         apply("R2/R3/R4/R6/R10", 0);
      end

      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
   end

endmodule